// File: doc/BRIEF.md
# Closed-Loop Flash Array Erase Sequencer

This block erases an entire byte-wide flash array from the host side. It drives the device command bus and works in two phases. First it brings every byte to the charged state, 00H, with a pulse-and-verify program loop that a byte program engine inside the block runs. Then it gives whole-array erase pulses. After each pulse a verify sweep reads bytes upward and stops at the first one that has not yet reached FFH.

The address where a sweep stops is kept. After the next erase pulse the sweep resumes from that address, so bytes that already verified are never read again. A pulse is timed by a cycle counter, and the number of program attempts per byte and of erase pulses are both capped. Software pulses `start` and waits for `done` or `fail`. The array size, pulse lengths and caps are parameters.

Command bus rules: a request is offered with `bus_valid`. While `bus_valid` is high and `bus_ready` is low, the block holds `bus_write`, `bus_addr` and `bus_wdata` unchanged. A read returns exactly one `rsp_valid` cycle some cycles after it is accepted. The block issues no further request until that response arrives.

Top module: `erase_array_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `bus_valid` are all low.
- R2: Before any erase command, every address from 0 to the last is programmed in ascending order. One attempt is a write of 40H, then a write of data 00H, then a gap of at least PROG_PULSE_CYC cycles, then a write of C0H, then a read. All of these go to the byte's address. A read of 00H moves on to the next address.
- R3: A byte whose verify read is not 00H gets another attempt, up to PROG_MAX_TRIES attempts. If the last attempt also fails, the block raises `fail` and issues no erase command.
- R4: An erase pulse is two consecutive writes of 20H, followed by at least ERASE_PULSE_CYC cycles with no bus request.
- R5: Each erase verify is a write of A0H carrying the byte address, followed by a read of that same address. A read of FFH moves the sweep up by one address.
- R6: A sweep stops at the first byte that does not read FFH. After the next pulse, verification resumes at that address and never revisits lower ones.
- R7: When the last address reads FFH, `done` rises and stays high until the next `start`. No bus request is made while `done` or `fail` is high.
- R8: If a sweep still stops after ERASE_MAX_PULSES pulses, `fail` rises with exactly that many pulses given.
- R9: Request fields stay stable while the bus stalls, and no request is made while a read is outstanding.
- R10: A `start` pulse while `busy` is high has no effect on the running sequence.
- R11: `done` and `fail` are never high together, and both clear on the cycle after an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a full erase when idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Array verified erased |
| fail | output | 1 | A program or erase cap was exceeded |
| bus_valid | output | 1 | Command bus request valid |
| bus_ready | input | 1 | Device accepts the request |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Byte address |
| bus_wdata | output | 8 | Write data or command code |
| rsp_valid | input | 1 | Read data valid (one cycle) |
| rsp_data | input | 8 | Read data |

## Verification
A stale or restarted verify address shows at once as extra erase-verify reads, so the per-run read count no longer matches the sweep worked out from the per-byte erase needs. A wrong attempt or pulse counter shows as a program-write or pulse count that is off by one, or as `done` where `fail` was due, at the end of that run. A timer that ends early shows on the very next request after the pulse, as a gap shorter than the set length. A mux or handshake fault shows within one cycle as a request field changing while stalled.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
  localparam logic [7:0] CMD_PROG_VERIFY  = 8'hC0;
  localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
  localparam logic [7:0] CMD_ERASE_VERIFY = 8'hA0;
  localparam logic [7:0] BYTE_CHARGED     = 8'h00;
  localparam logic [7:0] BYTE_CLEARED     = 8'hFF;

  typedef enum logic [2:0] {
    PG_IDLE, PG_SETUP, PG_DATA, PG_PULSE, PG_VCMD, PG_READ, PG_WAIT
  } pg_state_t;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_PREP_GO, SQ_PREP_WAIT, SQ_ESETUP, SQ_ECONF,
    SQ_EPULSE, SQ_EVCMD, SQ_EREAD, SQ_EWAIT
  } sq_state_t;
endpackage

// File: rtl/erase_pulse_timer.sv
module erase_pulse_timer #(
  parameter int unsigned CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)             remain <= '0;
    else if (load)          remain <= CW'(CYCLES);
    else if (remain != '0)  remain <= remain - CW'(1);
  end

  assign expired = (remain == '0) && !load;

  // R4: a freshly loaded timer never reports expiry on the next cycle
  a_r4_timer_arms: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired);
endmodule

// File: rtl/erase_byte_prog.sv
module erase_byte_prog
  import erase_seq_pkg::*;
#(
  parameter int unsigned AW        = 17,
  parameter int unsigned PULSE_CYC = 500,
  parameter int unsigned MAX_TRIES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] addr,
  output logic          ok,
  output logic          bad,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [7:0]    req_wdata,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_data
);
  localparam int TW = $clog2(MAX_TRIES + 1);

  pg_state_t     st;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] tries;
  logic          t_load, t_exp;

  assign t_load = (st == PG_DATA) && req_ready;

  erase_pulse_timer #(.CYCLES(PULSE_CYC)) u_ptimer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .expired(t_exp)
  );

  always_comb begin
    req_valid = (st == PG_SETUP) || (st == PG_DATA) ||
                (st == PG_VCMD)  || (st == PG_READ);
    req_write = (st != PG_READ);
    req_addr  = addr_q;
    unique case (st)
      PG_SETUP: req_wdata = CMD_PROG_SETUP;
      PG_VCMD:  req_wdata = CMD_PROG_VERIFY;
      default:  req_wdata = BYTE_CHARGED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= PG_IDLE;
      addr_q <= '0;
      tries  <= '0;
      ok     <= 1'b0;
      bad    <= 1'b0;
    end else begin
      ok  <= 1'b0;
      bad <= 1'b0;
      unique case (st)
        PG_IDLE:  if (go) begin
                    addr_q <= addr;
                    tries  <= '0;
                    st     <= PG_SETUP;
                  end
        PG_SETUP: if (req_ready) st <= PG_DATA;
        PG_DATA:  if (req_ready) begin
                    tries <= tries + TW'(1);
                    st    <= PG_PULSE;
                  end
        PG_PULSE: if (t_exp) st <= PG_VCMD;
        PG_VCMD:  if (req_ready) st <= PG_READ;
        PG_READ:  if (req_ready) st <= PG_WAIT;
        PG_WAIT:  if (rsp_valid) begin
                    if (rsp_data == BYTE_CHARGED) begin
                      ok <= 1'b1;
                      st <= PG_IDLE;
                    end else if (tries == TW'(MAX_TRIES)) begin
                      bad <= 1'b1;
                      st  <= PG_IDLE;
                    end else begin
                      st <= PG_SETUP;
                    end
                  end
        default:  st <= PG_IDLE;
      endcase
    end
  end

  // R3: attempt counter never passes its cap
  a_r3_try_cap: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TW'(MAX_TRIES));
  // R9: request fields held during a stall
  a_r9_pg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_wdata) && $stable(req_write)));
  // R3: ok and bad never together
  a_r3_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && bad));
endmodule

// File: rtl/erase_array_seq.sv
module erase_array_seq
  import erase_seq_pkg::*;
#(
  parameter int unsigned AW               = 17,
  parameter int unsigned PROG_PULSE_CYC   = 500,
  parameter int unsigned ERASE_PULSE_CYC  = 500000,
  parameter int unsigned PROG_MAX_TRIES   = 25,
  parameter int unsigned ERASE_MAX_PULSES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_data
);
  localparam int EW = $clog2(ERASE_MAX_PULSES + 1);
  localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

  sq_state_t     st;
  logic [AW-1:0] prep_addr, vaddr;
  logic [EW-1:0] epulses;
  logic          in_prep, in_erase;
  logic          e_load, e_exp;

  logic          pg_ok, pg_bad, pg_valid, pg_write;
  logic [AW-1:0] pg_addr;
  logic [7:0]    pg_wdata;
  logic          own_valid, own_write;
  logic [7:0]    own_wdata;

  assign in_prep  = (st == SQ_PREP_GO) || (st == SQ_PREP_WAIT);
  assign in_erase = (st == SQ_ESETUP) || (st == SQ_ECONF) || (st == SQ_EPULSE) ||
                    (st == SQ_EVCMD)  || (st == SQ_EREAD) || (st == SQ_EWAIT);
  assign busy     = (st != SQ_IDLE);
  assign e_load   = (st == SQ_ECONF) && bus_ready;

  erase_byte_prog #(
    .AW(AW), .PULSE_CYC(PROG_PULSE_CYC), .MAX_TRIES(PROG_MAX_TRIES)
  ) u_prog (
    .clk(clk), .rst_n(rst_n),
    .go(st == SQ_PREP_GO), .addr(prep_addr),
    .ok(pg_ok), .bad(pg_bad),
    .req_valid(pg_valid), .req_ready(bus_ready && in_prep),
    .req_write(pg_write), .req_addr(pg_addr), .req_wdata(pg_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  erase_pulse_timer #(.CYCLES(ERASE_PULSE_CYC)) u_etimer (
    .clk(clk), .rst_n(rst_n), .load(e_load), .expired(e_exp)
  );

  always_comb begin
    own_valid = (st == SQ_ESETUP) || (st == SQ_ECONF) ||
                (st == SQ_EVCMD)  || (st == SQ_EREAD);
    own_write = (st != SQ_EREAD);
    own_wdata = (st == SQ_EVCMD) ? CMD_ERASE_VERIFY : CMD_ERASE_SETUP;
    if (in_prep) begin
      bus_valid = pg_valid;
      bus_write = pg_write;
      bus_addr  = pg_addr;
      bus_wdata = pg_wdata;
    end else begin
      bus_valid = own_valid;
      bus_write = own_write;
      bus_addr  = vaddr;
      bus_wdata = own_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      prep_addr <= '0;
      vaddr     <= '0;
      epulses   <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE:      if (start) begin
                        done      <= 1'b0;
                        fail      <= 1'b0;
                        prep_addr <= '0;
                        st        <= SQ_PREP_GO;
                      end
        SQ_PREP_GO:   st <= SQ_PREP_WAIT;
        SQ_PREP_WAIT: if (pg_bad) begin
                        fail <= 1'b1;
                        st   <= SQ_IDLE;
                      end else if (pg_ok) begin
                        if (prep_addr == LAST_ADDR) begin
                          vaddr   <= '0;
                          epulses <= '0;
                          st      <= SQ_ESETUP;
                        end else begin
                          prep_addr <= prep_addr + AW'(1);
                          st        <= SQ_PREP_GO;
                        end
                      end
        SQ_ESETUP:    if (bus_ready) st <= SQ_ECONF;
        SQ_ECONF:     if (bus_ready) begin
                        epulses <= epulses + EW'(1);
                        st      <= SQ_EPULSE;
                      end
        SQ_EPULSE:    if (e_exp) st <= SQ_EVCMD;
        SQ_EVCMD:     if (bus_ready) st <= SQ_EREAD;
        SQ_EREAD:     if (bus_ready) st <= SQ_EWAIT;
        SQ_EWAIT:     if (rsp_valid) begin
                        if (rsp_data == BYTE_CLEARED) begin
                          if (vaddr == LAST_ADDR) begin
                            done <= 1'b1;
                            st   <= SQ_IDLE;
                          end else begin
                            vaddr <= vaddr + AW'(1);
                            st    <= SQ_EVCMD;
                          end
                        end else if (epulses == EW'(ERASE_MAX_PULSES)) begin
                          fail <= 1'b1;
                          st   <= SQ_IDLE;
                        end else begin
                          st <= SQ_ESETUP;
                        end
                      end
        default:      st <= SQ_IDLE;
      endcase
    end
  end

  // Read-outstanding tracker used by the protocol check below
  logic rd_out;
  always_ff @(posedge clk) begin
    if (!rst_n)                                rd_out <= 1'b0;
    else if (bus_valid && bus_ready && !bus_write) rd_out <= 1'b1;
    else if (rsp_valid)                        rd_out <= 1'b0;
  end

  a_r9_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out |-> !bus_valid);
  a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_wdata) && $stable(bus_write)));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  a_r8_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    epulses <= EW'(ERASE_MAX_PULSES));
  a_r6_no_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (in_erase && $past(in_erase)) |-> (vaddr >= $past(vaddr)));
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !bus_valid);
endmodule

// File: tb/erase_array_seq_tb_top.sv
module erase_array_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int N    = 16;
  localparam int PPC  = 5;
  localparam int EPC  = 20;
  localparam int PMAX = 4;
  localparam int EMAX = 6;

  typedef struct packed {
    logic [7:0] pn_addr; logic [7:0] pn;
    logic [7:0] mul; logic [7:0] add; logic [7:0] md;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd0,  8'd1, 8'd0, 8'd0, 8'd1},
    '{8'd3,  8'd2, 8'd1, 8'd0, 8'd4},
    '{8'd15, 8'd4, 8'd5, 8'd2, 8'd6},
    '{8'd7,  8'd5, 8'd1, 8'd0, 8'd2},
    '{8'd0,  8'd1, 8'd3, 8'd1, 8'd7},
    '{8'd9,  8'd3, 8'd0, 8'd3, 8'd8}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, fail, bus_valid, bus_write, bus_ready;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, rsp_data;
  logic rsp_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_array_seq #(.AW(AW), .PROG_PULSE_CYC(PPC), .ERASE_PULSE_CYC(EPC),
                    .PROG_MAX_TRIES(PMAX), .ERASE_MAX_PULSES(EMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  int applied = 0, miscmp = 0;
  int cur_pa, cur_pn, cur_mul, cur_add, cur_md;

  function automatic int pneed(int a);
    return (a == cur_pa) ? cur_pn : 1;
  endfunction
  function automatic int eneed(int a);
    return ((a * cur_mul + cur_add) % cur_md) + 1;
  endfunction

  // ---------------- device model and bus monitor ----------------
  int prog_cnt [N];
  int prog_ok, prog_wr, pulses, ev_reads, last_prep;
  int v_order, v_data, v_proto, v_gap, v_quiet, v_evaddr;
  logic arm_prog, arm_erase, erase_seen;
  logic [1:0] mode;            // 1 = program verify, 2 = erase verify
  logic [AW-1:0] ev_addr, r_addr;
  logic [1:0] r_mode;
  int rsp_cnt, gcnt, glim;
  logic gap_on;
  logic [7:0] lfsr;
  logic p_stall, p_write;
  logic [AW-1:0] p_addr;
  logic [7:0] p_wdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) prog_cnt[i] <= 0;
      prog_ok <= 0; prog_wr <= 0; pulses <= 0; ev_reads <= 0; last_prep <= 0;
      v_order <= 0; v_data <= 0; v_proto <= 0; v_gap <= 0; v_quiet <= 0; v_evaddr <= 0;
      arm_prog <= 0; arm_erase <= 0; erase_seen <= 0; mode <= 0; ev_addr <= '0;
      r_addr <= '0; r_mode <= 0; rsp_cnt <= 0; gcnt <= 0; glim <= 0; gap_on <= 0;
      lfsr <= 8'hA5; bus_ready <= 1'b0; rsp_valid <= 1'b0; rsp_data <= 8'h00;
      p_stall <= 0; p_write <= 0; p_addr <= '0; p_wdata <= 8'h00;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bus_ready <= lfsr[1] | lfsr[3];
      // R9 stability and single outstanding read
      if (p_stall && (!bus_valid || bus_addr != p_addr || bus_wdata != p_wdata ||
                      bus_write != p_write)) v_proto <= v_proto + 1;
      if ((rsp_cnt != 0 || rsp_valid) && bus_valid) v_proto <= v_proto + 1;
      p_stall <= bus_valid && !bus_ready;
      p_addr <= bus_addr; p_wdata <= bus_wdata; p_write <= bus_write;
      if ((done || fail) && bus_valid) v_quiet <= v_quiet + 1;
      // R2/R4 minimum gaps
      if (gap_on) begin
        gcnt <= gcnt + 1;
        if (bus_valid) begin
          if (gcnt < glim) v_gap <= v_gap + 1;
          gap_on <= 0;
        end
      end
      if (bus_valid && bus_ready && bus_write) begin
        if (arm_prog) begin
          arm_prog <= 0;
          prog_cnt[bus_addr] <= prog_cnt[bus_addr] + 1;
          prog_wr <= prog_wr + 1;
          if (bus_wdata != 8'h00) v_data <= v_data + 1;
          gap_on <= 1; gcnt <= 0; glim <= PPC;
        end else if (bus_wdata == 8'h40) begin
          arm_prog <= 1;
          if (erase_seen || int'(bus_addr) < last_prep) v_order <= v_order + 1;
          last_prep <= int'(bus_addr);
        end else if (bus_wdata == 8'h20) begin
          if (!erase_seen && prog_ok != N) v_order <= v_order + 1;
          erase_seen <= 1;
          if (arm_erase) begin
            arm_erase <= 0; pulses <= pulses + 1;
            gap_on <= 1; gcnt <= 0; glim <= EPC;
          end else arm_erase <= 1;
        end else if (bus_wdata == 8'hC0) mode <= 2'd1;
        else if (bus_wdata == 8'hA0) begin mode <= 2'd2; ev_addr <= bus_addr; end
      end
      if (bus_valid && bus_ready && !bus_write) begin
        rsp_cnt <= 2; r_addr <= bus_addr; r_mode <= mode;
        if (mode == 2'd2) begin
          ev_reads <= ev_reads + 1;
          if (bus_addr != ev_addr) v_evaddr <= v_evaddr + 1;
        end
      end else if (rsp_cnt == 2) rsp_cnt <= 1;
      rsp_valid <= 1'b0;
      if (rsp_cnt == 1) begin
        rsp_cnt <= 0; rsp_valid <= 1'b1;
        if (r_mode == 2'd1) begin
          if (prog_cnt[r_addr] >= pneed(int'(r_addr))) begin
            rsp_data <= 8'h00; prog_ok <= prog_ok + 1;
          end else rsp_data <= 8'h01;
        end else begin
          rsp_data <= (pulses >= eneed(int'(r_addr))) ? 8'hFF : 8'h7F;
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(string req, int act, int exp);
    applied++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_reads(int np);
    int v = 0, r = 0;
    for (int k = 1; k <= np; k++) begin
      while (v < N && eneed(v) <= k) begin r++; v++; end
      if (v < N) r++;
    end
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(vec_t v, int restart_at);
    int maxn = 0, exp_p, exp_wr;
    bit pfail;
    cur_pa = int'(v.pn_addr); cur_pn = int'(v.pn);
    cur_mul = int'(v.mul); cur_add = int'(v.add); cur_md = int'(v.md);
    do_reset();
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int c = 0; c < 40000 && !(done || fail); c++) begin
      if (c == restart_at) begin start = 1'b1; @(negedge clk); start = 1'b0; end
      else @(negedge clk);
    end
    repeat (10) @(negedge clk);
    for (int a = 0; a < N; a++) if (eneed(a) > maxn) maxn = eneed(a);
    pfail = (cur_pn > PMAX);
    exp_wr = pfail ? (cur_pa + PMAX) : (N - 1 + cur_pn);
    exp_p  = pfail ? 0 : ((maxn <= EMAX) ? maxn : EMAX);
    chk("R7 done", int'(done), (!pfail && maxn <= EMAX) ? 1 : 0);
    chk(pfail ? "R3 fail" : "R8 fail", int'(fail), (pfail || maxn > EMAX) ? 1 : 0);
    chk("R3 program attempts", prog_wr, exp_wr);
    chk("R8 erase pulses", pulses, exp_p);
    chk("R6 verify reads", ev_reads, pfail ? 0 : exp_reads(exp_p));
    chk("R2 order and data", v_order + v_data, 0);
    chk("R4 pulse gaps", v_gap, 0);
    chk("R5 verify address", v_evaddr, 0);
    chk("R9 protocol", v_proto, 0);
    chk("R7 quiet when finished", v_quiet, 0);
    chk("R11 exclusive", int'(done && fail), 0);
  endtask

  // ---------------- watchdog ----------------
  bit finished = 0;
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      applied++; miscmp++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done/fail", int'(done | fail), 0);
    chk("R1 bus_valid", int'(bus_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'(busy | bus_valid), 0);

    for (int i = 0; i < NV; i++) run(VECS[i], -1);

    // R10: a second start mid-run changes nothing
    run(VECS[1], 60);

    // R11: flags clear after a new start
    chk("R11 done before restart", int'(done), 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R11 done cleared", int'(done), 0);
    chk("R11 busy after start", int'(busy), 1);
    for (int c = 0; c < 40000 && !(done || fail); c++) @(negedge clk);
    chk("R7 done again", int'(done), 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end
endmodule